// File: doc/BRIEF.md
# Per-Thread Commit Event Counters

This block sits beside the commit stage of a multi-threaded out-of-order core and watches what retires. Every clock cycle the commit stage offers a group of commit slots. Each slot has a valid bit, the thread number of its instruction and a set of class flags: software prefetch, control flow, memory reference, load and memory barrier. The block sorts the flags by thread and by class, adds up all slots of the same cycle, and accumulates the totals in saturating counters that are kept separately for every hardware thread.

The block also measures commit bandwidth pressure. When every slot of a cycle is in use, the commit width limit has been reached. In such a cycle, each thread's count of instructions that were eligible but not committed is added to a per-thread shortfall counter. A single shared counter records how many such cycles occurred. Any counter can be read combinationally by giving a thread number and a counter index. A synchronous clear zeroes every counter at once.

Top module: `commit_evt_counters`

## Requirements
- R1: Counts are kept per thread and keyed by each slot's `slot_tid`. A valid slot whose thread number is not below THREADS adds to no counter. It still uses a slot for the width-limit test in R6.
- R2: A valid slot with the prefetch flag adds one to counter index 1 (prefetches) and not to index 0. A valid slot without it adds one to index 0 (instructions).
- R3: A valid slot with the control flag adds one to index 2 (branches).
- R4: A valid slot with the memory flag adds one to index 3 (references). If its load flag is also set, it adds one to index 4 (loads) as well. A load flag without the memory flag has no effect.
- R5: A valid slot with the barrier flag adds one to index 5 (barriers), whatever its other flags are.
- R6: When all SLOTS slots are valid, each thread t adds max(elig_cnt[t] − committed[t], 0) to its index 6. Here committed[t] is the number of valid slots for t in that cycle. In any other cycle, index 6 does not change.
- R7: Index 7 is one shared counter. It goes up by one in every cycle where all slots are valid, and it reads the same for every in-range thread number.
- R8: All slots of one cycle that hit the same thread and counter are summed, so the counter moves by the full count in one cycle.
- R9: Every counter is CNT_W bits wide (default 32). It saturates at all-ones and does not wrap.
- R10: `clr` zeroes every counter at the next rising edge. It takes priority over any increments in the same cycle.
- R11: `rd_data` shows the addressed counter in the same cycle, reflecting all edges seen so far. It reads zero when `rd_tid` is not below THREADS.
- R12: Flags on slots whose valid bit is low have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of all counters |
| slot_vld | input | SLOTS | Commit slot valid bits |
| slot_tid | input | SLOTS*TID_W | Thread number per slot, slot s at bits s*TID_W |
| slot_pref | input | SLOTS | Software prefetch flag per slot |
| slot_ctrl | input | SLOTS | Control-flow flag per slot |
| slot_mem | input | SLOTS | Memory reference flag per slot |
| slot_load | input | SLOTS | Load flag per slot |
| slot_bar | input | SLOTS | Memory barrier flag per slot |
| elig_cnt | input | THREADS*ELIG_W | Per-thread count of instructions eligible to commit |
| rd_tid | input | TID_W | Thread number to read |
| rd_idx | input | 3 | Counter index to read (0..7) |
| rd_data | output | CNT_W | Selected counter value |

## Verification
Slot and eligibility inputs are captured at the rising edge where they are presented. The counters change on that same edge. The read port has no register, so a result becomes visible right after that one edge, and a change on `rd_tid` or `rd_idx` shows within the same cycle. The bench drives stimulus on the falling edge. After the next rising edge, during the low half of the clock, it sweeps the read address over every thread and index with a short settle step per read. It compares each value with a reference model that it updates at the moment it drives the stimulus. Saturation is checked on a second, narrow copy of the block, where the limit can be reached in a few dozen cycles.

// File: rtl/cec_pkg.sv
package cec_pkg;
  // counters that follow each thread, plus one shared index
  localparam int SLOT_CLASSES = 6;
  localparam int THREAD_CNTS  = 7;
  localparam int IDX_W        = 3;

  typedef enum logic [IDX_W-1:0] {
    CI_INST   = 3'd0,
    CI_PREF   = 3'd1,
    CI_BRANCH = 3'd2,
    CI_REF    = 3'd3,
    CI_LOAD   = 3'd4,
    CI_BAR    = 3'd5,
    CI_BWLEFT = 3'd6,
    CI_BWEVT  = 3'd7
  } cnt_sel_e;

  // instructions left behind in a width-limited cycle, never negative
  function automatic int unsigned left_behind(int unsigned elig, int unsigned done);
    return (elig > done) ? elig - done : 0;
  endfunction
endpackage

// File: rtl/cec_slot_tally.sv
module cec_slot_tally
  import cec_pkg::*;
#(
  parameter int SLOTS   = 4,
  parameter int THREADS = 3,
  parameter int TID_W   = 2,
  parameter int INC_W   = 3
) (
  input  logic [SLOTS-1:0]                                vld_i,
  input  logic [SLOTS*TID_W-1:0]                          tid_i,
  input  logic [SLOTS-1:0]                                pref_i,
  input  logic [SLOTS-1:0]                                ctrl_i,
  input  logic [SLOTS-1:0]                                mem_i,
  input  logic [SLOTS-1:0]                                load_i,
  input  logic [SLOTS-1:0]                                bar_i,
  output logic [THREADS-1:0][SLOT_CLASSES-1:0][INC_W-1:0] inc_o,
  output logic [THREADS-1:0][INC_W-1:0]                   done_o,
  output logic                                            full_o
);
  localparam logic [INC_W-1:0] ONE = INC_W'(1);

  always_comb begin
    inc_o  = '0;
    done_o = '0;
    for (int t = 0; t < THREADS; t++) begin
      for (int s = 0; s < SLOTS; s++) begin
        if (vld_i[s] && (int'(tid_i[s*TID_W +: TID_W]) == t)) begin
          done_o[t] = done_o[t] + ONE;
          if (pref_i[s]) inc_o[t][CI_PREF] = inc_o[t][CI_PREF] + ONE;
          else           inc_o[t][CI_INST] = inc_o[t][CI_INST] + ONE;
          if (ctrl_i[s]) inc_o[t][CI_BRANCH] = inc_o[t][CI_BRANCH] + ONE;
          if (mem_i[s]) begin
            inc_o[t][CI_REF] = inc_o[t][CI_REF] + ONE;
            if (load_i[s]) inc_o[t][CI_LOAD] = inc_o[t][CI_LOAD] + ONE;
          end
          if (bar_i[s]) inc_o[t][CI_BAR] = inc_o[t][CI_BAR] + ONE;
        end
      end
    end
    full_o = &vld_i;
  end
endmodule

// File: rtl/cec_sat_counter.sv
module cec_sat_counter #(
  parameter int CNT_W = 32,
  parameter int INC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic [INC_W-1:0] inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] TOP = '1;

  function automatic logic [CNT_W-1:0] sat_add(logic [CNT_W-1:0] a, logic [INC_W-1:0] b);
    logic [CNT_W:0] s;
    s = {1'b0, a} + (CNT_W+1)'(b);
    return s[CNT_W] ? TOP : s[CNT_W-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else            cnt_o <= sat_add(cnt_o, inc_i);
  end

  // R10: clear wins over any increment
  p_clear_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_o == '0));
  // R9: an all-ones counter stays there
  p_no_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && cnt_o == TOP) |=> (cnt_o == TOP));
  // R9: without clear the value never goes down
  p_monotonic_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> (cnt_o >= $past(cnt_o)));
endmodule

// File: rtl/commit_evt_counters.sv
module commit_evt_counters
  import cec_pkg::*;
#(
  parameter int SLOTS   = 4,
  parameter int THREADS = 3,
  parameter int CNT_W   = 32,
  parameter int ELIG_W  = 4,
  localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic [SLOTS-1:0]          slot_vld,
  input  logic [SLOTS*TID_W-1:0]    slot_tid,
  input  logic [SLOTS-1:0]          slot_pref,
  input  logic [SLOTS-1:0]          slot_ctrl,
  input  logic [SLOTS-1:0]          slot_mem,
  input  logic [SLOTS-1:0]          slot_load,
  input  logic [SLOTS-1:0]          slot_bar,
  input  logic [THREADS*ELIG_W-1:0] elig_cnt,
  input  logic [TID_W-1:0]          rd_tid,
  input  logic [IDX_W-1:0]          rd_idx,
  output logic [CNT_W-1:0]          rd_data
);
  localparam int INC_W = $clog2(SLOTS + 1);
  localparam int ADD_W = (INC_W > ELIG_W) ? INC_W : ELIG_W;

  // named internal events
  logic [THREADS-1:0][SLOT_CLASSES-1:0][INC_W-1:0] slot_inc;
  logic [THREADS-1:0][INC_W-1:0]                   thr_done;
  logic                                            bw_full;
  logic [THREADS-1:0][ADD_W-1:0]                   thr_left;
  logic [THREADS-1:0][THREAD_CNTS-1:0][CNT_W-1:0]  cnt_w;
  logic [CNT_W-1:0]                                bw_evt_cnt;

  cec_slot_tally #(
    .SLOTS(SLOTS), .THREADS(THREADS), .TID_W(TID_W), .INC_W(INC_W)
  ) u_tally (
    .vld_i (slot_vld),  .tid_i (slot_tid),  .pref_i(slot_pref),
    .ctrl_i(slot_ctrl), .mem_i (slot_mem),  .load_i(slot_load),
    .bar_i (slot_bar),  .inc_o (slot_inc),  .done_o(thr_done),
    .full_o(bw_full)
  );

  always_comb begin
    for (int t = 0; t < THREADS; t++) begin
      thr_left[t] = bw_full
        ? ADD_W'(left_behind(int'(elig_cnt[t*ELIG_W +: ELIG_W]), int'(thr_done[t])))
        : '0;
    end
  end

  for (genvar t = 0; t < THREADS; t++) begin : g_thr
    for (genvar c = 0; c < SLOT_CLASSES; c++) begin : g_cls
      cec_sat_counter #(.CNT_W(CNT_W), .INC_W(ADD_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr_i(clr),
        .inc_i(ADD_W'(slot_inc[t][c])), .cnt_o(cnt_w[t][c])
      );
    end
    cec_sat_counter #(.CNT_W(CNT_W), .INC_W(ADD_W)) u_left (
      .clk(clk), .rst_n(rst_n), .clr_i(clr),
      .inc_i(thr_left[t]), .cnt_o(cnt_w[t][CI_BWLEFT])
    );

    // R4: loads are a subset of memory references
    p_load_subset_r4: assert property (@(posedge clk) disable iff (!rst_n)
      slot_inc[t][CI_LOAD] <= slot_inc[t][CI_REF]);
    // R12: no valid slot, no change to the instruction counter
    p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_vld == '0 && !clr) |=> $stable(cnt_w[t][CI_INST]));
    // R6: shortfall counter only moves in width-limited cycles
    p_left_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!bw_full && !clr) |=> $stable(cnt_w[t][CI_BWLEFT]));
  end

  cec_sat_counter #(.CNT_W(CNT_W), .INC_W(1)) u_evt (
    .clk(clk), .rst_n(rst_n), .clr_i(clr),
    .inc_i(bw_full), .cnt_o(bw_evt_cnt)
  );

  always_comb begin
    rd_data = '0;
    if (int'(rd_tid) < THREADS) begin
      if (rd_idx == CI_BWEVT) rd_data = bw_evt_cnt;
      else                    rd_data = cnt_w[rd_tid][rd_idx];
    end
  end

  // R7: one step per width-limited cycle below saturation
  p_evt_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bw_full && !clr && bw_evt_cnt != '1) |=> (bw_evt_cnt == $past(bw_evt_cnt) + 1'b1));
  // R11: out-of-range thread reads zero
  p_oob_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd_tid) >= THREADS) |-> (rd_data == '0));
endmodule

// File: tb/commit_evt_counters_bench.sv
module commit_evt_counters_bench;
  localparam int CLK_PERIOD = 100;
  localparam int NS = 4;
  localparam int NT = 3;
  localparam int EW = 4;
  localparam longint MAXV = 64'hFFFF_FFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic [NS-1:0] slot_vld = '0, slot_pref = '0, slot_ctrl = '0, slot_mem = '0,
                 slot_load = '0, slot_bar = '0;
  logic [NS*2-1:0] slot_tid = '0;
  logic [NT*EW-1:0] elig_cnt = '0;
  logic [1:0] rd_tid = '0;
  logic [2:0] rd_idx = '0;
  logic [31:0] rd_data;
  logic [5:0]  rd_data_s;

  int nchk = 0, nfail = 0;
  bit finished = 0;

  // stimulus mirror
  bit [NS-1:0] v, p, c, m, l, b;
  int tid [NS];
  int el [NT];
  longint mdl [NT][7];
  longint evt;

  always #(CLK_PERIOD/2) clk = ~clk;

  commit_evt_counters u_commit_evt_counters (
    .clk, .rst_n, .clr, .slot_vld, .slot_tid, .slot_pref, .slot_ctrl,
    .slot_mem, .slot_load, .slot_bar, .elig_cnt, .rd_tid, .rd_idx, .rd_data
  );

  commit_evt_counters #(.CNT_W(6)) u_narrow (
    .clk, .rst_n, .clr, .slot_vld, .slot_tid, .slot_pref, .slot_ctrl,
    .slot_mem, .slot_load, .slot_bar, .elig_cnt, .rd_tid, .rd_idx,
    .rd_data(rd_data_s)
  );

  task automatic chk(string tag, longint act, longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic string tag_of(int i);
    case (i)
      0, 1: return "R2";
      2:    return "R3";
      3, 4: return "R4";
      5:    return "R5";
      6:    return "R6";
      default: return "R7";
    endcase
  endfunction

  function automatic longint sat(longint a, longint d);
    return (a + d > MAXV) ? MAXV : a + d;
  endfunction

  task automatic model_clear();
    for (int t = 0; t < NT; t++) for (int i = 0; i < 7; i++) mdl[t][i] = 0;
    evt = 0;
  endtask

  // reference model: applied at the edge the stimulus is presented
  task automatic model_step(bit cl);
    int done [NT];
    if (cl) begin model_clear(); return; end
    for (int t = 0; t < NT; t++) done[t] = 0;
    for (int s = 0; s < NS; s++) begin
      if (v[s] && tid[s] < NT) begin
        done[tid[s]]++;
        if (p[s]) mdl[tid[s]][1] = sat(mdl[tid[s]][1], 1);
        else      mdl[tid[s]][0] = sat(mdl[tid[s]][0], 1);
        if (c[s]) mdl[tid[s]][2] = sat(mdl[tid[s]][2], 1);
        if (m[s]) begin
          mdl[tid[s]][3] = sat(mdl[tid[s]][3], 1);
          if (l[s]) mdl[tid[s]][4] = sat(mdl[tid[s]][4], 1);
        end
        if (b[s]) mdl[tid[s]][5] = sat(mdl[tid[s]][5], 1);
      end
    end
    if (v == '1) begin
      evt = sat(evt, 1);
      for (int t = 0; t < NT; t++)
        if (el[t] > done[t]) mdl[t][6] = sat(mdl[t][6], el[t] - done[t]);
    end
  endtask

  // called at a falling edge: drive, pass one rising edge, return at falling edge
  task automatic step(bit cl);
    slot_vld = v; slot_pref = p; slot_ctrl = c; slot_mem = m;
    slot_load = l; slot_bar = b; clr = cl;
    for (int s = 0; s < NS; s++) slot_tid[s*2 +: 2] = 2'(tid[s]);
    for (int t = 0; t < NT; t++) elig_cnt[t*EW +: EW] = 4'(el[t]);
    model_step(cl);
    @(posedge clk);
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic rd(int t, int i, output longint val);
    rd_tid = 2'(t); rd_idx = 3'(i);
    #1;
    val = rd_data;
  endtask

  task automatic check_all();
    longint val;
    for (int t = 0; t < NT; t++)
      for (int i = 0; i < 8; i++) begin
        rd(t, i, val);
        chk($sformatf("%s t%0d idx%0d", tag_of(i), t, i), val, (i == 7) ? evt : mdl[t][i]);
      end
    for (int i = 0; i < 8; i++) begin
      rd(3, i, val);
      chk($sformatf("R11 out-of-range read idx%0d", i), val, 0);
    end
  endtask

  task automatic zero_stim();
    v = '0; p = '0; c = '0; m = '0; l = '0; b = '0;
    for (int s = 0; s < NS; s++) tid[s] = 0;
    for (int t = 0; t < NT; t++) el[t] = 0;
  endtask

  task automatic finish_run();
    if (finished) return;
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nchk++; nfail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    longint val;
    void'($urandom(32'd4711));
    zero_stim();
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state
    check_all();

    // R8 R12: two prefetches and one plain inst on thread 1, invalid slot with flags
    v = 4'b0111; p = 4'b1011; c = 4'b1000; m = 4'b1000; b = 4'b1000;
    tid[0] = 1; tid[1] = 1; tid[2] = 1; tid[3] = 1; el[1] = 9;
    step(0);
    rd(1, 1, val); chk("R8 two prefetches summed in one cycle", val, 2);
    rd(1, 2, val); chk("R12 invalid slot control flag ignored", val, 0);
    rd(1, 6, val); chk("R6 no shortfall when not width limited", val, 0);
    check_all();

    // R4: load flag without memory flag; R5 barrier alone
    zero_stim();
    v = 4'b1111; tid[0] = 2; tid[1] = 2; tid[2] = 0; tid[3] = 0;
    l = 4'b0011; m = 4'b0010; b = 4'b0100; el[2] = 7; el[0] = 1;
    step(0);
    rd(2, 4, val); chk("R4 load without mem not counted", val, 1);
    rd(0, 6, val); chk("R6 elig below committed adds zero", val, 0);
    rd(2, 6, val); chk("R6 shortfall of thread 2", val, 5);
    rd(0, 7, val); chk("R7 limit event counted", val, 1);
    check_all();

    // R1: out-of-range thread number slots counted nowhere
    zero_stim();
    v = 4'b1111; tid[0] = 3; tid[1] = 3; tid[2] = 3; tid[3] = 0;
    c = 4'b1111; el[0] = 3;
    step(0);
    rd(0, 2, val); chk("R1 only in-range slot counted", val, 1);
    rd(0, 6, val); chk("R1 full-slot test includes out-of-range slots", val, 2);
    check_all();

    // R10: clear with simultaneous increments
    zero_stim();
    v = 4'b1111; c = 4'b1111; el[0] = 15;
    step(1);
    rd(0, 2, val); chk("R10 clear beats same-cycle increment", val, 0);
    rd(0, 7, val); chk("R10 event counter cleared", val, 0);
    check_all();

    // constrained random
    for (int n = 0; n < 300; n++) begin
      v = ($urandom % 10 < 4) ? 4'hF : 4'($urandom);
      p = 4'($urandom & $urandom); c = 4'($urandom); m = 4'($urandom);
      l = 4'($urandom); b = 4'($urandom & $urandom);
      for (int s = 0; s < NS; s++) tid[s] = ($urandom % 8 == 0) ? 3 : int'($urandom % 3);
      for (int t = 0; t < NT; t++) el[t] = int'($urandom % 16);
      step(($urandom % 50) == 0);
      check_all();
    end

    // R9: saturation on the narrow copy (6-bit counters, limit 63)
    zero_stim();
    step(1);
    v = 4'b1111; c = 4'b1111; m = 4'b1111; el[0] = 15;
    for (int k = 0; k < 10; k++) step(0);
    rd_tid = 2'd0; rd_idx = 3'd2; #1;
    chk("R9 narrow branch before limit", rd_data_s, 40);
    rd_idx = 3'd6; #1;
    chk("R9 narrow shortfall saturated", rd_data_s, 63);
    rd_idx = 3'd7; #1;
    chk("R9 narrow events", rd_data_s, 10);
    for (int k = 0; k < 10; k++) step(0);
    rd_tid = 2'd0; rd_idx = 3'd2; #1;
    chk("R9 narrow branch saturated", rd_data_s, 63);
    rd_idx = 3'd3; #1;
    chk("R9 narrow reference saturated", rd_data_s, 63);
    rd_idx = 3'd7; #1;
    chk("R9 narrow events before limit", rd_data_s, 20);
    check_all();

    finish_run();
  end
endmodule